// File: doc/BRIEF.md
# Indexed Peripheral Clock Divider Controller

This block gates and divides the clock enables of up to 64 peripherals from one master clock. Every peripheral has a stored enable bit and a 2-bit divide setting that acts as a shift. The peripheral ticks at the master rate divided by 1, 2, 4 or 8. All settings are reached through a single indirect control word.

Each write carries a peripheral ID. It also carries a command flag that decides what the write does. With the flag set, the write applies the enable and divide values to that peripheral. With the flag clear, the write only picks which peripheral the read port reports.

A free-running 3-bit prescaler is shared by all peripherals and gives the phase. A peripheral with divide d pulses its enable once every 2^d master cycles. A new divide value waits for the prescaler to wrap, so no period is ever cut short. The two lowest IDs are hard-wired: they are always enabled and never divided.

Top module: `pclk_div_ctrl`

## Requirements
- R1: The control word uses these bits: ID in bits 5:0, command flag in bit 12, divide in bits 17:16, enable in bit 28. `rd_data` returns the selected ID in bits 5:0, its divide in bits 17:16 and its enable in bit 28. Every other bit of `rd_data`, including bit 12, reads 0.
- R2: A write with bit 12 set to a configurable ID stores that ID's enable and divide. `rd_data` shows the new values in the cycle after the write edge.
- R3: Every write latches its ID as the readback selection. A write with bit 12 clear changes no peripheral's enable or divide.
- R4: IDs below `FIXED_IDS` (0 and 1) ignore command writes. They always read back enable 1 and divide 0, and their `clk_en` bits are high in every cycle.
- R5: During and right after reset, every configurable peripheral is disabled with divide 0. The selected ID is 0, and `clk_en` is low for all configurable IDs.
- R6: The prescaler starts at 0 after reset and steps by one every master cycle, wrapping from 7 to 0. An enabled peripheral with active divide d has `clk_en` high exactly in the cycles where the low d prescaler bits are zero.
- R7: A disabled peripheral's `clk_en` stays low. An enable change shows on `clk_en` in the cycle after the write edge.
- R8: A stored divide becomes the active divide only at the edge where the prescaler goes from 7 to 0. Until then the previous active divide keeps setting the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 32 | Control word being written |
| rd_data | output | 32 | Readback of the selected peripheral |
| clk_en | output | NUM_PERIPH | Per-peripheral divided clock enable |

## Verification
The bench builds the block with its default parameters: 64 peripherals, two of them fixed, and the full 6-bit ID space. With these values every ID can be swept, including both fixed IDs and the highest one. A reference model of the prescaler and of each peripheral's stored and active divide predicts the whole enable vector on every cycle. This puts every divide-to-divide change at every prescaler phase within reach, together with writes that land on the wrap edge itself.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  // Width of the divide (shift) field and of the prescaler it selects from
  localparam int DIV_W = 2;
  localparam int PRE_W = (1 << DIV_W) - 1;

  // Control word layout
  localparam int CTRL_W     = 32;
  localparam int ID_FIELD_W = 6;
  localparam int ID_LSB     = 0;
  localparam int CMD_BIT    = 12;
  localparam int DIV_LSB    = 16;
  localparam int EN_BIT     = 28;

  typedef struct packed {
    logic             en;
    logic [DIV_W-1:0] div;
  } slot_cfg_t;

  // True when the prescaler phase is a multiple of 2**div
  function automatic logic pclk_tick_hit(input logic [PRE_W-1:0] cnt,
                                         input logic [DIV_W-1:0] div);
    logic [PRE_W-1:0] mask;
    mask = PRE_W'((32'd1 << div) - 32'd1);
    return (cnt & mask) == '0;
  endfunction

  function automatic logic [ID_FIELD_W-1:0] pclk_word_id(input logic [CTRL_W-1:0] w);
    return w[ID_LSB +: ID_FIELD_W];
  endfunction

  function automatic slot_cfg_t pclk_word_cfg(input logic [CTRL_W-1:0] w);
    slot_cfg_t c;
    c.en  = w[EN_BIT];
    c.div = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] pclk_pack_rd(input logic [ID_FIELD_W-1:0] id,
                                                     input slot_cfg_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[ID_LSB +: ID_FIELD_W] = id;
    w[DIV_LSB +: DIV_W]     = c.div;
    w[EN_BIT]               = c.en;
    return w;
  endfunction

endpackage

// File: rtl/pclk_prescaler.sv
module pclk_prescaler
  import pclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] pre_cnt,
  output logic             pre_wrap
);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign pre_cnt  = cnt_q;
  assign pre_wrap = (cnt_q == '1);

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wrap |=> (pre_cnt == '0));

endmodule

// File: rtl/pclk_slot.sv
module pclk_slot
  import pclk_div_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int FIXED = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  slot_cfg_t        wr_cfg,
  input  logic             pre_wrap,
  input  logic [PRE_W-1:0] pre_cnt,
  output slot_cfg_t        cfg_out,
  output logic             clk_en
);

  generate
    if (IDX < FIXED) begin : g_fixed
      logic unused_fixed;
      assign unused_fixed = ^{clk, rst_n, wr_hit, wr_cfg, pre_wrap, pre_cnt};
      assign cfg_out.en   = 1'b1;
      assign cfg_out.div  = '0;
      assign clk_en       = 1'b1;
    end else begin : g_live
      slot_cfg_t        cfg_q;
      logic [DIV_W-1:0] act_div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q     <= '0;
          act_div_q <= '0;
        end else begin
          if (wr_hit)   cfg_q     <= wr_cfg;
          if (pre_wrap) act_div_q <= cfg_q.div;
        end
      end

      assign cfg_out = cfg_q;
      assign clk_en  = cfg_q.en & pclk_tick_hit(pre_cnt, act_div_q);

      // R3
      cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(cfg_out));

      // R8
      act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_wrap |=> $stable(act_div_q));
    end
  endgenerate

endmodule

// File: rtl/pclk_regif.sv
module pclk_regif
  import pclk_div_pkg::*;
#(
  parameter int NUM   = 64,
  parameter int FIXED = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CTRL_W-1:0]       wr_data,
  input  slot_cfg_t [NUM-1:0]     cfg_vec,
  output logic                    wr_cmd,
  output logic [ID_FIELD_W-1:0]   wr_id,
  output slot_cfg_t               wr_cfg,
  output logic [CTRL_W-1:0]       rd_data
);

  logic [ID_FIELD_W-1:0] sel_q;
  logic                  unused_bits;

  assign wr_id       = pclk_word_id(wr_data);
  assign wr_cfg      = pclk_word_cfg(wr_data);
  assign wr_cmd      = wr_en & wr_data[CMD_BIT];
  assign unused_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_id;
  end

  always_comb begin
    if (int'(sel_q) < NUM) rd_data = pclk_pack_rd(sel_q, cfg_vec[sel_q]);
    else                   rd_data = pclk_pack_rd(sel_q, '0);
  end

  // R4
  fixed_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_data[ID_LSB +: ID_FIELD_W]) < FIXED) |->
      (rd_data[EN_BIT] && rd_data[DIV_LSB +: DIV_W] == '0));

endmodule

// File: rtl/pclk_div_ctrl.sv
module pclk_div_ctrl
  import pclk_div_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int FIXED_IDS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  output logic [NUM_PERIPH-1:0] clk_en
);

  localparam int ID_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

  logic                  wr_cmd;
  logic [ID_FIELD_W-1:0] wr_id;
  slot_cfg_t             wr_cfg;
  logic [PRE_W-1:0]      pre_cnt;
  logic                  pre_wrap;
  slot_cfg_t [NUM_PERIPH-1:0] cfg_vec;
  logic [NUM_PERIPH-1:0] wr_hit;

  pclk_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_cnt  (pre_cnt),
    .pre_wrap (pre_wrap)
  );

  pclk_regif #(.NUM(NUM_PERIPH), .FIXED(FIXED_IDS)) u_regif (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_vec (cfg_vec),
    .wr_cmd  (wr_cmd),
    .wr_id   (wr_id),
    .wr_cfg  (wr_cfg),
    .rd_data (rd_data)
  );

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
    assign wr_hit[i] = wr_cmd & (wr_id == ID_FIELD_W'(i));

    pclk_slot #(.IDX(i), .FIXED(FIXED_IDS)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit[i]),
      .wr_cfg   (wr_cfg),
      .pre_wrap (pre_wrap),
      .pre_cnt  (pre_cnt),
      .cfg_out  (cfg_vec[i]),
      .clk_en   (clk_en[i])
    );
  end

  // R2
  cmd_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CMD_BIT] && int'(wr_data[ID_W-1:0]) >= FIXED_IDS) |=>
      (rd_data[EN_BIT] == $past(wr_data[EN_BIT]) &&
       rd_data[DIV_LSB +: DIV_W] == $past(wr_data[DIV_LSB +: DIV_W])));

  // R3
  sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[ID_LSB +: ID_FIELD_W] == $past(wr_data[ID_LSB +: ID_FIELD_W])));

  // R7
  disable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CMD_BIT] && !wr_data[EN_BIT] &&
     int'(wr_data[ID_W-1:0]) >= FIXED_IDS) |=> !clk_en[$past(wr_data[ID_W-1:0])]);

endmodule

// File: tb/test_pclk_div_ctrl.sv
`timescale 1ns/1ps
module test_pclk_div_ctrl;

  localparam int N  = 64;
  localparam int FX = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit run_chk = 0;

  always #2.5 clk = ~clk;

  pclk_div_ctrl #(.NUM_PERIPH(N), .FIXED_IDS(FX)) i_pclk_div_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_en(clk_en)
  );

  // Requirement-level model
  int       m_cnt;
  bit       m_en  [N];
  int       m_div [N];
  int       m_act [N];
  int       m_sel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0;
      m_sel <= 0;
      for (int i = 0; i < N; i++) begin
        m_en[i] <= 0; m_div[i] <= 0; m_act[i] <= 0;
      end
    end else begin
      m_cnt <= (m_cnt + 1) % 8;
      if (m_cnt == 7)
        for (int i = 0; i < N; i++) m_act[i] <= m_div[i];
      if (wr_en) begin
        m_sel <= int'(wr_data[5:0]);
        if (wr_data[12] && int'(wr_data[5:0]) >= FX) begin
          m_en[wr_data[5:0]]  <= wr_data[28];
          m_div[wr_data[5:0]] <= int'(wr_data[17:16]);
        end
      end
    end
  end

  function automatic logic [N-1:0] exp_clk_en();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      if (i < FX) v[i] = 1'b1;
      else        v[i] = m_en[i] && ((m_cnt % (1 << m_act[i])) == 0);
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] w;
    w = 32'(m_sel);
    if (m_sel < FX) w[28] = 1'b1;
    else begin
      w[28] = m_en[m_sel];
      w[17:16] = 2'(m_div[m_sel]);
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Continuous per-cycle checks of the enable vector: R6, R7, R8 and R4
  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      check(clk_en === exp_clk_en(), "R6/R7/R8 clk_en", clk_en, exp_clk_en());
      check(clk_en[1:0] === 2'b11, "R4 fixed clk_en", 64'(clk_en[1:0]), 64'h3);
    end
  end

  localparam logic [31:0] JUNK = 32'hE00C0FC0;

  task automatic wr(input int id, input bit cmd, input bit en, input int dv,
                    input string req);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = JUNK;
    wr_data[5:0]   = 6'(id);
    wr_data[12]    = cmd;
    wr_data[17:16] = 2'(dv);
    wr_data[28]    = en;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
    check(rd_data === exp_rd(), req, 64'(rd_data), 64'(exp_rd()));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R5: reset state
    repeat (3) @(negedge clk);
    check(clk_en[N-1:FX] === '0, "R5 reset clk_en", 64'(clk_en), 64'h3);
    check(rd_data === 32'h1000_0000, "R5/R1 reset readback", 64'(rd_data), 64'h1000_0000);
    rst_n = 1'b1;
    run_chk = 1;
    check(clk_en[N-1:FX] === '0, "R5 after reset clk_en", 64'(clk_en), 64'h3);
    idle(16);

    // R2: enable every ID with a divide from its index
    for (int id = 0; id < N; id++) begin
      wr(id, 1'b1, 1'b1, id % 4, "R2/R4 cmd write readback");
      idle(id % 3);
    end
    idle(24);

    // R3: select-only writes carrying misleading fields
    for (int id = 0; id < N; id++)
      wr(id, 1'b0, ~id[0], (id + 1) % 4, "R3/R1 select readback");
    idle(24);

    // R8: divide changes at every prescaler phase
    for (int k = 0; k < 32; k++) begin
      wr(7, 1'b1, 1'b1, k % 4, "R8 div change readback");
      idle(k % 9);
    end
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        wr(9, 1'b1, 1'b1, a, "R8 div pair a");
        idle(b);
        wr(9, 1'b1, 1'b1, b, "R8 div pair b");
        idle(10);
      end

    // R7: disable even IDs, then re-enable some
    for (int id = FX; id < N; id += 2)
      wr(id, 1'b1, 1'b0, 3, "R7 disable readback");
    idle(20);
    for (int id = FX; id < N; id += 4)
      wr(id, 1'b1, 1'b1, 0, "R7 re-enable readback");
    idle(20);

    // R4: command writes to fixed IDs are ignored
    wr(0, 1'b1, 1'b0, 3, "R4 fixed id0");
    wr(1, 1'b1, 1'b0, 2, "R4 fixed id1");
    idle(10);
    wr(N - 1, 1'b0, 1'b0, 0, "R1 top id select");
    idle(10);

    run_chk = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule